// File: doc/BRIEF.md
# Handshake-Ordered Latch Enable Sequencer

This block replaces a single global clock with a chain of small latch-enable controllers, one per latch. Each edge-triggered register of a clocked design is split into a master latch and a slave latch. Each controller decides when its own latch opens and closes by looking only at its two neighbours. The datapath between latches stays as it was. Data items move through the latches as tokens, and the order in which enables fire makes every latch store the same sequence of values that a clocked register chain would store.

The controllers are modelled cycle by cycle on a sampling clock. A latch "opens" when its enable goes high, and it captures its input at that edge. It "closes" when the enable goes low. The block can be built as an open pipeline or as a closed ring, and each latch selects its own ordering protocol through a packed parameter.

The protocol codes are 0 semi-decoupled, 1 fully decoupled, 2 non-overlapping and 3 simple four-phase. In a pipeline, latch 0 takes `in_data` from a source that always has data, and the last latch feeds a sink that always accepts. A ring must have an even latch count of at least four and may not use the simple protocol, because that protocol can deadlock a ring. Either violation stops elaboration with an error. A stall monitor raises `stalled` when no enable has changed for `STALL_LIMIT` consecutive cycles.

Top module: `dsq_sequencer`

## Requirements
- R1: While `rst` is high, even-numbered (master) latches are closed and odd-numbered (slave) latches are open. Master latch of pair p holds (17*p + 90) mod 2^W.
- R2: A latch's value changes only on the clock edge at which its enable rises.
- R3: In a ring, latch i captures from latch i-1, and latch 0 captures from latch N-1. A master (even) latch applies f(x) = (x rotated left by one bit) + 1 mod 2^W to its input, and a slave (odd) latch copies its input. The c-th capture of every latch equals the value the same latch would hold in a clocked master/slave chain with the same reset contents.
- R4: In a pipeline, the c-th capture of latch 0 is the value on `in_data` at the edge where it opens. Every other latch follows the same clocked-chain rule as in R3.
- R5: A non-overlapping (code 2) latch opens only when both of its neighbours were closed in the cycle before.
- R6: A semi-decoupled (code 0) latch opens only when its successor was closed in the cycle before.
- R7: A latch with code 0, 1 or 2 keeps its enable high for exactly one cycle each time it opens.
- R8: A simple (code 3) latch closes only on an edge where its successor's enable was already high.
- R9: Two adjacent latches never open on the same edge.
- R10: With a legal ring configuration, every latch keeps opening, with at least 15 captures in 120 cycles, and `stalled` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock of the controller model |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | W | Source data for latch 0 in pipeline mode; unused in ring mode |
| lat_en | output | N | Enable of each latch, 1 = open (transparent) |
| lat_q | output | N*W | Stored value of each latch, latch i at bits [i*W +: W] |
| stalled | output | 1 | High after STALL_LIMIT cycles with no enable change |

## Verification
An enable rise and the capture it causes both appear one edge after the conditions that allow them. For codes 0 to 2, the enable falls on the very next edge. The bench therefore samples every output at the falling clock edge. It compares the current sample with the sample taken one cycle earlier, which is the state just before the edge that produced the change, and checks each neighbour condition against that earlier sample. Each capture is checked against a table of clocked-chain reference values indexed by that latch's own capture count. In the pipeline, the bench moves `in_data` to the next item in the half cycle after latch 0 opens, well before latch 0 can open again two edges later.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

  // Per-latch ordering protocol, two bits per latch in the PROTO vector.
  typedef enum logic [1:0] {
    PR_SEMI   = 2'd0,
    PR_FULL   = 2'd1,
    PR_NONOV  = 2'd2,
    PR_SIMPLE = 2'd3
  } proto_e;

endpackage

// File: rtl/dsq_ctrl.sv
// Enable controller of one latch: fires open and close events from neighbour state.
module dsq_ctrl
  import dsq_pkg::*;
#(
  parameter proto_e PROTO      = PR_FULL,
  parameter bit     RESET_OPEN = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic pred_tok,   // predecessor holds an item not yet taken
  input  logic own_tok,    // this latch holds an item not yet taken
  input  logic pred_en,
  input  logic succ_en,
  input  logic succ_ok,    // successor open (or sink) for simple-protocol close
  output logic en,
  output logic open_ev,
  output logic close_ev
);
  localparam bit CHK_SUCC = (PROTO != PR_FULL);
  localparam bit CHK_PRED = (PROTO == PR_NONOV);
  localparam bit HOLD     = (PROTO == PR_SIMPLE);

  logic en_q;
  logic can_take;

  assign can_take = pred_tok & ~own_tok & ~en_q;
  assign open_ev  = can_take & ~(CHK_SUCC & succ_en) & ~(CHK_PRED & pred_en);
  assign close_ev = en_q & (~HOLD | succ_ok);

  always_ff @(posedge clk) begin
    if (rst)           en_q <= RESET_OPEN;
    else if (open_ev)  en_q <= 1'b1;
    else if (close_ev) en_q <= 1'b0;
  end

  assign en = en_q;
endmodule

// File: rtl/dsq_slot.sv
// Data latch and token flag of one stage.
module dsq_slot #(
  parameter int         W         = 8,
  parameter bit         RESET_TOK = 1'b0,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         open_ev,
  input  logic         take_ev,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         tok
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= RESET_VAL;
      tok <= RESET_TOK;
    end else if (open_ev) begin
      q   <= din;
      tok <= 1'b1;
    end else if (take_ev) begin
      tok <= 1'b0;
    end
  end
endmodule

// File: rtl/dsq_stall_mon.sv
// Flags a run of STALL_LIMIT cycles without any enable change.
module dsq_stall_mon #(
  parameter int N           = 8,
  parameter int STALL_LIMIT = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] en,
  output logic         stalled
);
  localparam int CW = $clog2(STALL_LIMIT + 1);

  logic [N-1:0]  en_prev;
  logic [CW-1:0] quiet;
  logic          moved;

  assign moved = (en != en_prev);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_prev <= '0;
      quiet   <= '0;
    end else begin
      en_prev <= en;
      if (moved)                       quiet <= '0;
      else if (quiet != CW'(STALL_LIMIT)) quiet <= quiet + 1'b1;
    end
  end

  assign stalled = (quiet == CW'(STALL_LIMIT));
endmodule

// File: rtl/dsq_sequencer.sv
module dsq_sequencer
  import dsq_pkg::*;
#(
  parameter int             N           = 8,
  parameter int             W           = 8,
  parameter bit             RING        = 1'b1,
  parameter logic [2*N-1:0] PROTO       = 16'h4849,
  parameter int             STALL_LIMIT = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   in_data,
  output logic [N-1:0]   lat_en,
  output logic [N*W-1:0] lat_q,
  output logic           stalled
);
  // Master-side combinational function between pairs.
  function automatic logic [W-1:0] step_fn(input logic [W-1:0] x);
    return {x[W-2:0], x[W-1]} + W'(1);
  endfunction

  // Reset contents of the master latch of pair p.
  function automatic logic [W-1:0] init_val(input int p);
    return W'(p * 17 + 90);
  endfunction

  function automatic bit has_simple(input logic [2*N-1:0] pv);
    bit r = 1'b0;
    for (int k = 0; k < N; k++)
      if (pv[2*k +: 2] == 2'd3) r = 1'b1;
    return r;
  endfunction

  localparam bit BAD_SHAPE = (N < 2) || (N % 2 != 0) || (RING && N < 4);
  localparam bit BAD_RING  = RING && has_simple(PROTO);

  if (BAD_SHAPE) begin : g_bad_shape
    $error("dsq_sequencer: latch count must be even (and at least 4 in a ring)");
  end
  if (BAD_RING) begin : g_bad_ring
    $error("dsq_sequencer: simple protocol in a ring can deadlock");
  end

  logic [N-1:0] tok, open_ev, close_ev, take_ev;
  logic [N-1:0] pred_tok_v, pred_en_v, succ_en_v, succ_ok_v;
  logic [W-1:0] q   [N];
  logic [W-1:0] din [N];

  if (RING) begin : g_ring_in
    logic unused_in;
    assign unused_in = ^in_data;
  end

  for (genvar i = 0; i < N; i++) begin : g_lat
    localparam int     PI      = (i == 0) ? N - 1 : i - 1;
    localparam int     SI      = (i == N - 1) ? 0 : i + 1;
    localparam bit     MASTER  = (i % 2 == 0);
    localparam proto_e PR      = proto_e'(PROTO[2*i +: 2]);

    if (!RING && i == 0) begin : g_src
      assign pred_tok_v[i] = 1'b1;
      assign pred_en_v[i]  = 1'b0;
      assign din[i]        = in_data;
    end else begin : g_pred
      assign pred_tok_v[i] = tok[PI];
      assign pred_en_v[i]  = lat_en[PI];
      if (MASTER) begin : g_fn
        assign din[i] = step_fn(q[PI]);
      end else begin : g_cp
        assign din[i] = q[PI];
      end
    end

    if (!RING && i == N - 1) begin : g_sink
      assign succ_en_v[i] = 1'b0;
      assign succ_ok_v[i] = 1'b1;
      assign take_ev[i]   = tok[i];
    end else begin : g_succ
      assign succ_en_v[i] = lat_en[SI];
      assign succ_ok_v[i] = lat_en[SI];
      assign take_ev[i]   = open_ev[SI];
    end

    dsq_ctrl #(
      .PROTO     (PR),
      .RESET_OPEN(!MASTER)
    ) u_ctrl (
      .clk     (clk),
      .rst     (rst),
      .pred_tok(pred_tok_v[i]),
      .own_tok (tok[i]),
      .pred_en (pred_en_v[i]),
      .succ_en (succ_en_v[i]),
      .succ_ok (succ_ok_v[i]),
      .en      (lat_en[i]),
      .open_ev (open_ev[i]),
      .close_ev(close_ev[i])
    );

    dsq_slot #(
      .W        (W),
      .RESET_TOK(MASTER),
      .RESET_VAL(MASTER ? init_val(i / 2) : '0)
    ) u_slot (
      .clk    (clk),
      .rst    (rst),
      .open_ev(open_ev[i]),
      .take_ev(take_ev[i]),
      .din    (din[i]),
      .q      (q[i]),
      .tok    (tok[i])
    );

    assign lat_q[i*W +: W] = q[i];
  end

  logic unused_close;
  assign unused_close = ^close_ev;

  dsq_stall_mon #(
    .N          (N),
    .STALL_LIMIT(STALL_LIMIT)
  ) u_stall (
    .clk    (clk),
    .rst    (rst),
    .en     (lat_en),
    .stalled(stalled)
  );
endmodule

// File: rtl/dsq_checker.sv
module dsq_checker #(
  parameter int             N     = 8,
  parameter int             W     = 8,
  parameter bit             RING  = 1'b1,
  parameter logic [2*N-1:0] PROTO = 16'h4849
) (
  input logic           clk,
  input logic           rst,
  input logic [N-1:0]   en,
  input logic [N-1:0]   open_ev,
  input logic [N*W-1:0] q,
  input logic           stalled
);
  for (genvar i = 0; i < N; i++) begin : g_chk
    localparam int         PI   = (i == 0) ? N - 1 : i - 1;
    localparam int         SI   = (i == N - 1) ? 0 : i + 1;
    localparam bit         HASP = RING || (i > 0);
    localparam bit         HASS = RING || (i < N - 1);
    localparam logic [1:0] PC   = PROTO[2*i +: 2];

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !open_ev[i] |=> $stable(q[i*W +: W]));

    if (PC != 2'd3) begin : g_pulse
      p_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        en[i] |=> !en[i]);
    end

    if (PC == 2'd2 && HASP && HASS) begin : g_nonov
      p_nonov_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(en[i]) |-> (!en[PI] && !en[SI]));
    end

    if (PC == 2'd0 && HASS) begin : g_semi
      p_semi_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(en[i]) |-> $past(!en[SI]));
    end

    if (PC == 2'd3 && HASS) begin : g_simple
      p_simple_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(en[i]) |-> $past(en[SI]));
    end

    if (HASS) begin : g_adj
      p_adjacent_r9: assert property (@(posedge clk) disable iff (rst)
        !($rose(en[i]) && $rose(en[SI])));
    end
  end

  p_stall_r10: assert property (@(posedge clk) disable iff (rst)
    stalled |-> $stable(en));
endmodule

bind dsq_sequencer dsq_checker #(
  .N    (N),
  .W    (W),
  .RING (RING),
  .PROTO(PROTO)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .en     (lat_en),
  .open_ev(open_ev),
  .q      (lat_q),
  .stalled(stalled)
);

// File: tb/tb_dsq_sequencer.sv
module tb_dsq_sequencer;
  localparam int NR = 8;
  localparam int NP = 6;
  localparam int W  = 8;
  localparam int S  = 64;
  localparam logic [2*NR-1:0] RPROTO = 16'h4849;
  localparam logic [2*NP-1:0] PPROTO = 12'h631;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] in_data;
  always #2.5 clk = ~clk;

  logic [NR-1:0]   r_en;
  logic [NR*W-1:0] r_q;
  logic            r_stalled;
  logic [NP-1:0]   p_en;
  logic [NP*W-1:0] p_q;
  logic            p_stalled;

  dsq_sequencer #(.N(NR), .W(W), .RING(1'b1), .PROTO(RPROTO), .STALL_LIMIT(64)) dut (
    .clk(clk), .rst(rst), .in_data(in_data),
    .lat_en(r_en), .lat_q(r_q), .stalled(r_stalled));

  dsq_sequencer #(.N(NP), .W(W), .RING(1'b0), .PROTO(PPROTO), .STALL_LIMIT(64)) dut_pipe (
    .clk(clk), .rst(rst), .in_data(in_data),
    .lat_en(p_en), .lat_q(p_q), .stalled(p_stalled));

  int n_chk = 0;
  int n_fail = 0;
  int r_cap [NR];
  int p_cap [NP];
  int p_falls2 = 0;
  logic [NR-1:0]   r_prev;
  logic [NR*W-1:0] r_qprev;
  logic [NP-1:0]   p_prev;
  logic [NP*W-1:0] p_qprev;
  logic [W-1:0] ringref [S][NR/2];
  logic [W-1:0] piperef [S][NP/2];
  logic [W-1:0] item [S];

  function automatic logic [W-1:0] fref(input logic [W-1:0] x);
    logic [W:0] t;
    t = {1'b0, x} << 1;
    return (t[W-1:0] | W'(t[W])) + 8'd1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic build_refs();
    for (int k = 0; k < S; k++) item[k] = W'(k * 29 + 3);
    for (int p = 0; p < NR/2; p++) ringref[0][p] = W'(17 * p + 90);
    for (int p = 0; p < NP/2; p++) piperef[0][p] = W'(17 * p + 90);
    for (int s = 1; s < S; s++) begin
      for (int p = 0; p < NR/2; p++)
        ringref[s][p] = fref(ringref[s-1][(p + NR/2 - 1) % (NR/2)]);
      for (int p = 0; p < NP/2; p++)
        piperef[s][p] = (p == 0) ? item[s-1] : fref(piperef[s-1][p-1]);
    end
  endtask

  task automatic step();
    @(negedge clk);
    for (int i = 0; i < NR; i++) begin
      int s = (i + 1) % NR;
      int pm = (i + NR - 1) % NR;
      logic [1:0] pc = RPROTO[2*i +: 2];
      bit rose = r_en[i] && !r_prev[i];
      if (rose) begin
        r_cap[i]++;
        if (r_cap[i] < S) begin
          logic [W-1:0] e = (i % 2 == 0) ? ringref[r_cap[i]][i/2] : ringref[r_cap[i]-1][i/2];
          chk(r_q[i*W +: W] == e, "R3", r_q[i*W +: W], e);
        end
        if (pc == 2'd2) chk(!r_prev[pm] && !r_prev[s], "R5", {r_prev[pm], r_prev[s]}, 0);
        if (pc == 2'd0) chk(!r_prev[s], "R6", r_prev[s], 0);
        chk(!(r_en[s] && !r_prev[s]), "R9", r_en[s], 0);
      end else begin
        chk(r_q[i*W +: W] == r_qprev[i*W +: W], "R2", r_q[i*W +: W], r_qprev[i*W +: W]);
      end
      if (r_prev[i]) chk(!r_en[i], "R7", r_en[i], 0);
    end
    for (int i = 0; i < NP; i++) begin
      logic [1:0] pc = PPROTO[2*i +: 2];
      bit rose = p_en[i] && !p_prev[i];
      bit hs = (i < NP - 1);
      bit hp = (i > 0);
      if (rose) begin
        p_cap[i]++;
        if (p_cap[i] < S) begin
          logic [W-1:0] e = (i % 2 == 0) ? piperef[p_cap[i]][i/2] : piperef[p_cap[i]-1][i/2];
          chk(p_q[i*W +: W] == e, "R4", p_q[i*W +: W], e);
        end
        if (pc == 2'd2 && hs && hp) chk(!p_prev[i-1] && !p_prev[i+1], "R5", {p_prev[i-1], p_prev[i+1]}, 0);
        if (pc == 2'd0 && hs) chk(!p_prev[i+1], "R6", p_prev[i+1], 0);
        if (hs) chk(!(p_en[i+1] && !p_prev[i+1]), "R9", p_en[i+1], 0);
        if (i == 0 && p_cap[0] < S) in_data = item[p_cap[0]];
      end else begin
        chk(p_q[i*W +: W] == p_qprev[i*W +: W], "R2", p_q[i*W +: W], p_qprev[i*W +: W]);
      end
      if (pc != 2'd3 && p_prev[i]) chk(!p_en[i], "R7", p_en[i], 0);
      if (pc == 2'd3 && hs && p_prev[i] && !p_en[i]) begin
        p_falls2++;
        chk(p_prev[i+1], "R8", p_prev[i+1], 1);
      end
    end
    r_prev = r_en; r_qprev = r_q;
    p_prev = p_en; p_qprev = p_q;
  endtask

  task automatic t_reset_state();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(r_en == 8'hAA, "R1", r_en, 8'hAA);
    chk(p_en == 6'h2A, "R1", p_en, 6'h2A);
    for (int p = 0; p < NR/2; p++)
      chk(r_q[2*p*W +: W] == W'(17 * p + 90), "R1", r_q[2*p*W +: W], W'(17 * p + 90));
    for (int p = 0; p < NP/2; p++)
      chk(p_q[2*p*W +: W] == W'(17 * p + 90), "R1", p_q[2*p*W +: W], W'(17 * p + 90));
    r_prev = r_en; r_qprev = r_q;
    p_prev = p_en; p_qprev = p_q;
    rst = 1'b0;
  endtask

  task automatic t_ring_flow();
    repeat (120) step();
    for (int i = 0; i < NR; i++) chk(r_cap[i] >= 15, "R10", r_cap[i], 15);
    chk(!r_stalled, "R10", r_stalled, 0);
  endtask

  task automatic t_pipe_flow();
    repeat (120) step();
    for (int i = 0; i < NP; i++) chk(p_cap[i] >= 10, "R4", p_cap[i], 10);
    chk(p_falls2 >= 5, "R8", p_falls2, 5);
    chk(!p_stalled, "R4", p_stalled, 0);
  endtask

  initial begin
    foreach (r_cap[i]) r_cap[i] = 0;
    foreach (p_cap[i]) p_cap[i] = 0;
    build_refs();
    in_data = item[0];
    t_reset_state();
    t_ring_flow();
    t_pipe_flow();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule